// File: doc/BRIEF.md
# Variable-Width Index Stream Decoder

This block turns a packed block of buffer indexes into fixed 8-bit entries, ready to be written one after another into a local index buffer. A block holds `ROWS` rows of `COLS` indexes each. Every index in a row has the same width, and that width is set by a 3-bit code for the row. Different rows may use different widths. The packed bits arrive as bytes over a valid/ready handshake. The decoder pulls a byte only when the bits it already holds are too few for the next index. It writes each index out zero-extended to 8 bits, together with its sequential buffer address.

A block begins with a one-cycle `start_i` pulse, which captures the row codes. The decoder then alternates between two states. In `ST_FETCH` it waits for a byte. In `ST_EMIT` it cuts one index from the low end of its bit window. The transitions are:

- `ST_IDLE -> ST_FETCH` on start.
- `ST_FETCH -> ST_EMIT` when a byte is accepted.
- `ST_EMIT -> ST_EMIT` while the remaining bits still cover the next index width.
- `ST_EMIT -> ST_FETCH` when they do not.
- `ST_EMIT -> ST_IDLE` after the final index of the block.

Bits left over in the last byte are dropped, so every block starts on a byte boundary.

Top module: `vidx_decoder_top`

## Requirements
- R1: After reset, `idx_valid_o`, `blk_done_o`, `busy_o` and `byte_ready_o` are all low.
- R2: A `start_i` pulse while idle captures `codes_i` and raises `busy_o` on the next clock edge. A `start_i` pulse while busy is ignored, and the block in progress keeps its captured codes.
- R3: Row r's code sits in `codes_i[3r+2:3r]`. A code value c gives an index width of c+1 bits, from 1 to 8.
- R4: Indexes are packed LSB-first. Bit 0 of the first byte is bit 0 of the first index. An index may span two bytes.
- R5: Every emitted index is zero-extended to 8 bits. Bits above its width read as zero.
- R6: The first `COLS` indexes use row 0's width, the next `COLS` use row 1's width, and so on through row `ROWS-1`.
- R7: `idx_addr_o` counts 0, 1, 2 ... in step with the emitted indexes.
- R8: After exactly `ROWS*COLS` indexes, the decoder pulses `blk_done_o` together with the last index, then returns to idle. The remaining pad bits are discarded, so the next block starts at bit 0 of its first byte.
- R9: `byte_ready_o` is high only while the held bits are fewer than the current width. The decoder therefore takes exactly ceil(total bits / 8) bytes per block and no bytes while idle. A gap in `byte_valid_i` only delays the output. At most one index is emitted per cycle.
- R10: The internal bit window never holds more than 15 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a block; honoured only when idle |
| codes_i | input | ROWS*3 | Per-row width codes; row r at bits 3r+2..3r |
| byte_valid_i | input | 1 | A packed byte is offered |
| byte_i | input | 8 | Packed byte |
| byte_ready_o | output | 1 | Decoder accepts the offered byte this cycle |
| idx_valid_o | output | 1 | An index is presented |
| idx_o | output | 8 | Index, zero-extended |
| idx_addr_o | output | ADDR_W | Index buffer address of `idx_o` |
| blk_done_o | output | 1 | Last index of the block is presented |
| busy_o | output | 1 | A block is being decoded |

## Verification
A bit pointer that is off by even one bit corrupts every later index in the block. It appears at the ports as a wrong `idx_o` value one cycle after that index's emit state. A wrong row-width switch shows up at the first index of the affected row. A wrong count of fetched bytes shows up as a byte consumed too early or too late, which shifts everything after it. A miscount of the block length shows up as a missing or misplaced `blk_done_o`, or as a refused or stolen byte at the start of the next block. The scoreboard compares each value and address against expected values built from independently packed streams, so each of these faults is reported on the first affected index.

// File: rtl/vidx_pkg.sv
package vidx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } vidx_state_e;

    localparam int CODE_W = 3;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 4;
    localparam int WIN_W  = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(WIN_W) + 1;

    function automatic logic [LEN_W-1:0] code_to_len(input logic [CODE_W-1:0] code);
        return {1'b0, code} + LEN_W'(1);
    endfunction

endpackage

// File: rtl/vidx_code_table.sv
module vidx_code_table
    import vidx_pkg::*;
#(
    parameter int ROWS = 4,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [ROWS*CODE_W-1:0]   codes_i,
    input  logic [ROW_W-1:0]         row_i,
    output logic [LEN_W-1:0]         cur_len_o,
    output logic [LEN_W-1:0]         nxt_len_o
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic [CODE_W-1:0] code_q [ROWS];
    logic [ROW_W-1:0]  nxt_row;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[g] <= '0;
            end else if (load_i) begin
                code_q[g] <= codes_i[g*CODE_W +: CODE_W];
            end
        end
    end

    always_comb begin
        nxt_row   = (row_i == ROW_LAST) ? row_i : row_i + ROW_W'(1);
        cur_len_o = code_to_len(code_q[row_i]);
        nxt_len_o = code_to_len(code_q[nxt_row]);
    end

    // R3: every width handed to the datapath lies in 1..8
    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len_o >= LEN_W'(1)) && (cur_len_o <= LEN_W'(BYTE_W)));

endmodule

// File: rtl/vidx_bit_window.sv
module vidx_bit_window
    import vidx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              pop_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [BYTE_W-1:0] field_o,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [WIN_W-1:0]  win_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WIN_W-1:0]  ins;
    logic [BYTE_W:0]   mask;

    always_comb begin
        ins     = {{(WIN_W-BYTE_W){1'b0}}, byte_i} << cnt_q[CNT_W-2:0];
        mask    = ((BYTE_W+1)'(1) << len_i) - (BYTE_W+1)'(1);
        field_o = win_q[BYTE_W-1:0] & mask[BYTE_W-1:0];
        cnt_o   = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (push_i) begin
            win_q <= win_q | ins;
            cnt_q <= cnt_q + CNT_W'(BYTE_W);
        end else if (pop_i) begin
            win_q <= win_q >> len_i;
            cnt_q <= cnt_q - {1'b0, len_i};
        end
    end

    // R9: a byte is only taken while fewer than 8 bits are held
    assert_push_when_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < CNT_W'(BYTE_W)));

    // R9: an index is only cut when enough bits are held
    assert_pop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cnt_q >= {1'b0, len_i}));

    // R10: window never overflows
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WIN_W - 1));

    // R9: fetch and emit never share a cycle
    assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/vidx_position.sv
module vidx_position #(
    parameter int ROWS = 4,
    parameter int COLS = 3,
    localparam int TOTAL  = ROWS * COLS,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int ADDR_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    output logic [ROW_W-1:0]  row_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              row_end_o,
    output logic              last_o
);

    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(TOTAL - 1);

    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        row_o     = row_q;
        addr_o    = addr_q;
        row_end_o = (col_q == COL_LAST);
        last_o    = (addr_q == ADDR_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            addr_q <= '0;
        end else if (clr_i || (step_i && last_o)) begin
            col_q  <= '0;
            row_q  <= '0;
            addr_q <= '0;
        end else if (step_i) begin
            addr_q <= addr_q + ADDR_W'(1);
            if (row_end_o) begin
                col_q <= '0;
                row_q <= row_q + ROW_W'(1);
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end

    // R7: addresses advance by exactly one per emitted index
    assert_addr_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !last_o && !clr_i) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

endmodule

// File: rtl/vidx_decoder_top.sv
module vidx_decoder_top
    import vidx_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 3,
    localparam int TOTAL  = ROWS * COLS,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int ADDR_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ROWS*CODE_W-1:0]  codes_i,
    input  logic                    byte_valid_i,
    input  logic [BYTE_W-1:0]       byte_i,
    output logic                    byte_ready_o,
    output logic                    idx_valid_o,
    output logic [BYTE_W-1:0]       idx_o,
    output logic [ADDR_W-1:0]       idx_addr_o,
    output logic                    blk_done_o,
    output logic                    busy_o
);

    vidx_state_e state_q, state_d;

    logic              load, clr, push, pop;
    logic [ROW_W-1:0]  row;
    logic [ADDR_W-1:0] addr;
    logic              row_end, last;
    logic [LEN_W-1:0]  cur_len, nxt_len, next_len;
    logic [BYTE_W-1:0] field;
    logic [CNT_W-1:0]  cnt, rem;

    vidx_code_table #(.ROWS(ROWS)) u_codes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .codes_i   (codes_i),
        .row_i     (row),
        .cur_len_o (cur_len),
        .nxt_len_o (nxt_len)
    );

    vidx_bit_window u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .push_i  (push),
        .byte_i  (byte_i),
        .pop_i   (pop),
        .len_i   (cur_len),
        .field_o (field),
        .cnt_o   (cnt)
    );

    vidx_position #(.ROWS(ROWS), .COLS(COLS)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .step_i    (pop),
        .row_o     (row),
        .addr_o    (addr),
        .row_end_o (row_end),
        .last_o    (last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath control
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        clr      = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        rem      = cnt - {1'b0, cur_len};
        next_len = row_end ? nxt_len : cur_len;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load    = 1'b1;
                    clr     = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (byte_valid_i) begin
                    push    = 1'b1;
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                pop = 1'b1;
                if (last) begin
                    state_d = ST_IDLE;
                end else if (rem >= {1'b0, next_len}) begin
                    state_d = ST_EMIT;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    assign byte_ready_o = (state_q == ST_FETCH);
    assign busy_o       = (state_q != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_valid_o <= 1'b0;
            idx_o       <= '0;
            idx_addr_o  <= '0;
            blk_done_o  <= 1'b0;
        end else begin
            idx_valid_o <= pop;
            blk_done_o  <= pop && last;
            if (pop) begin
                idx_o      <= field;
                idx_addr_o <= addr;
            end
        end
    end

    // R5: the cut field carries nothing above the current width
    assert_zero_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> ((field >> cur_len) == '0));

    // R8: completion marks the final address
    assert_done_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |-> (idx_valid_o && (idx_addr_o == ADDR_W'(TOTAL - 1))));

    // R8: leaving busy only happens with completion
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> blk_done_o);

    // R2: a start while waiting for bytes does not end the block
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready_o && start_i) |=> busy_o);

endmodule

// File: tb/sim_vidx_decoder_top.sv
`timescale 1ns/1ps
module sim_vidx_decoder_top;

    localparam int ROWS  = 4;
    localparam int COLS  = 3;
    localparam int TOTAL = ROWS * COLS;
    localparam int AW    = $clog2(TOTAL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [ROWS*3-1:0] codes = '0;
    logic            bvalid = 1'b0;
    logic [7:0]      bdata = '0;
    logic            bready, ivalid, done, busy;
    logic [7:0]      idx;
    logic [AW-1:0]   addr;

    int checks = 0;
    int errors = 0;
    int dones  = 0;
    logic [15:0] exp_q [$];
    logic [15:0] e;

    always #4 clk = ~clk;

    vidx_decoder_top #(.ROWS(ROWS), .COLS(COLS)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .codes_i      (codes),
        .byte_valid_i (bvalid),
        .byte_i       (bdata),
        .byte_ready_o (bready),
        .idx_valid_o  (ivalid),
        .idx_o        (idx),
        .idx_addr_o   (addr),
        .blk_done_o   (done),
        .busy_o       (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (ivalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 extra index", int'(addr), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(idx == e[7:0], "R3 R4 R5 R6 index value", int'(idx), int'(e[7:0]));
                    check(addr == e[8 +: AW], "R7 address", int'(addr), int'(e[8 +: AW]));
                end
            end
            if (done) dones++;
        end
    end

    function automatic int next_rand(input int s);
        return (s * 1103515245 + 12345) & 32'h7fffffff;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        bvalid = 1'b1;
        bdata  = b;
        #1;
        while (!bready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        bvalid = 1'b0;
    endtask

    task automatic run_block(input logic [ROWS*3-1:0] cds, input int seed,
                             input bit ones, input bit gaps, input bit inj);
        logic [127:0] pk;
        int pos, nb, s, d0, w, v;
        pk = '0; pos = 0; s = seed;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                w = int'(cds[3*r +: 3]) + 1;
                v = ones ? ((1 << w) - 1) : ((s >> 7) & ((1 << w) - 1));
                s = next_rand(s);
                pk = pk | (128'(v) << pos);
                pos += w;
                exp_q.push_back({8'(r*COLS + c), 8'(v)});
            end
        end
        nb = (pos + 7) / 8;
        d0 = dones;
        @(negedge clk);
        start = 1'b1;
        codes = cds;
        @(negedge clk);
        start = 1'b0;
        codes = ~cds;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        for (int i = 0; i < nb; i++) begin
            if (gaps && (i % 2 == 1)) repeat (2) @(negedge clk);
            if (inj && i == 2) begin
                @(negedge clk);
                start = 1'b1;
                codes = '1;
                @(negedge clk);
                start = 1'b0;
                check(busy == 1'b1, "R2 start ignored while busy", int'(busy), 1);
            end
            send_byte(pk[8*i +: 8]);
        end
        while (dones == d0) @(negedge clk);
        @(negedge clk);
        check(dones == d0 + 1, "R8 one completion", dones - d0, 1);
        check(busy == 1'b0, "R8 idle after block", int'(busy), 0);
        check(exp_q.size() == 0, "R8 all indexes emitted", exp_q.size(), 0);
        // offer a stray byte while idle: must not be taken
        bvalid = 1'b1;
        bdata  = 8'hA5;
        repeat (3) begin
            @(negedge clk);
            check(bready == 1'b0, "R9 no byte taken while idle", int'(bready), 0);
            check(ivalid == 1'b0, "R9 no index while idle", int'(ivalid), 0);
        end
        bvalid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ivalid == 1'b0, "R1 valid in reset", int'(ivalid), 0);
        check(bready == 1'b0, "R1 ready in reset", int'(bready), 0);
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

        // mixed widths 3,1,8,5 (R3 R4 R6), 51 bits -> pad then realign (R8)
        run_block({3'd4, 3'd7, 3'd0, 3'd2}, 17, 1'b0, 1'b0, 1'b0);
        // all 8-bit, byte aligned
        run_block({3'd7, 3'd7, 3'd7, 3'd7}, 99, 1'b0, 1'b0, 1'b0);
        // all 1-bit, heavy reuse of one byte
        run_block({3'd0, 3'd0, 3'd0, 3'd0}, 5, 1'b0, 1'b0, 1'b0);
        // widths 4,2,7,6 with stalls and an ignored start (R2 R9)
        run_block({3'd5, 3'd6, 3'd1, 3'd3}, 1234, 1'b0, 1'b1, 1'b1);
        // all-ones values, widths 7,3,6,2: zero padding and straddles (R5)
        run_block({3'd1, 3'd5, 3'd2, 3'd6}, 1, 1'b1, 1'b0, 1'b0);
        // increasing widths 2..5 with stalls
        run_block({3'd4, 3'd3, 3'd2, 3'd1}, 77, 1'b0, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule